// File: doc/BRIEF.md
# Hash Engine Register and Interrupt Front-End

This block is the memory-mapped control face of a multi-algorithm hash engine. Software reaches it through a simple 32-bit register port. Through that port it can hold the engine in a soft reset, program the 64-bit message length in bits, and choose the algorithm and the byte order. It also handles interrupt status, enable and clear, reads three fixed identification words, and collects the finished digest one word per read from a result queue. The hash rounds and the data write path live elsewhere. A stub input loads a finished digest together with its completion pulse, and a strobe from the data write path reports each incoming data word.

The digest leaves through a pop-on-read queue whose depth follows the selected algorithm, and the highest-numbered word comes out first. Reading the queue when it is empty returns zero and raises an error flag. A second error flag records data that arrived before the control word was programmed. The interrupt output is the OR of the four status flags after masking with the enable register.

Top module: `hash_fe_top`

## Requirements
- R1: After reset every programmable register reads zero, the status reads zero, `irq` is low and `eng_rst` is low.
- R2: Offset 0x00 bit 0 drives `eng_rst`. Writing 1 also empties the result queue and marks the block as unconfigured. Writing 0 releases `eng_rst`.
- R3: Offsets 0x04 and 0x08 hold the high and low 32-bit halves of `msg_bits` and read back as written.
- R4: Offset 0x0C bits [1:0] select the algorithm (0 MD5, 1 SHA-1, 2 SHA-224, 3 SHA-256) on `algo`, and bits [9:8] drive `byte_order`. All other bits read as zero.
- R5: A `dig_load` pulse fills the queue with 4, 5, 7 or 8 words for algorithm 0, 1, 2 or 3. Each read of 0x1C returns and removes one word, starting from word N-1 and ending at word 0. Word i sits at `dig_word[32*i +: 32]`.
- R6: A read of 0x1C while the queue is empty returns zero and sets status bit 2.
- R7: A `dat_wr` strobe sets status bit 3 only if offset 0x0C has not been written since the last reset (hard reset or a write of 1 to 0x00). After such a write it has no effect.
- R8: A `dig_load` pulse sets status bits 0 and 1 (0x10).
- R9: Writing to 0x18 clears each status bit whose write-data bit is 1 and leaves the others unchanged. A set and a clear of the same bit in the same cycle leave the bit set.
- R10: Offset 0x14 bits [3:0] enable the status bits. Status bit 8 and `irq` both equal the OR of status[3:0] AND enable[3:0].
- R11: Offsets 0x50, 0x60 and 0x70 return the parameters `REV_ID`, `DESC0_ID` and `DESC1_ID`, and writes to them are ignored.
- R12: Reads of any other offset return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_req | input | 1 | Register access strobe |
| reg_wr | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 8 | Byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational in the access cycle |
| dig_load | input | 1 | Completion pulse from the engine, loads the digest |
| dig_word | input | 256 | Digest words, word i at bits 32*i+31:32*i |
| dat_wr | input | 1 | Strobe from the data write path |
| eng_rst | output | 1 | Soft reset to the engine |
| msg_bits | output | 64 | Message length in bits |
| algo | output | 2 | Algorithm select |
| byte_order | output | 2 | Byte-order select |
| irq | output | 1 | Interrupt request |

## Verification
The status flags have two sources: hardware events that set them and software clear writes that remove them. Both can act in the same cycle. The bench provokes this overlap in two ways. It pulses `dig_load` in the same cycle as a clear write of bit 1, and it pulses `dat_wr` while unconfigured in the same cycle as a clear write of bit 3. The status read that follows must still show each of those bits set. A third check clears a flag while leaving another flag in place, which confirms that a clear affects only the bits written as 1.

// File: rtl/hash_fe_pkg.sv
// Shared offsets, algorithm codes and the queue-depth rule for the hash
// register front-end. Assumes byte offsets on an 8-bit address.
package hash_fe_pkg;
    localparam logic [7:0] OFS_RST    = 8'h00;
    localparam logic [7:0] OFS_LEN_HI = 8'h04;
    localparam logic [7:0] OFS_LEN_LO = 8'h08;
    localparam logic [7:0] OFS_CTRL   = 8'h0C;
    localparam logic [7:0] OFS_STAT   = 8'h10;
    localparam logic [7:0] OFS_EN     = 8'h14;
    localparam logic [7:0] OFS_CLR    = 8'h18;
    localparam logic [7:0] OFS_RQ     = 8'h1C;
    localparam logic [7:0] OFS_REV    = 8'h50;
    localparam logic [7:0] OFS_DESC0  = 8'h60;
    localparam logic [7:0] OFS_DESC1  = 8'h70;

    localparam int NUM_FLAGS = 4;

    typedef enum logic [1:0] {
        ALG_MD5    = 2'd0,
        ALG_SHA1   = 2'd1,
        ALG_SHA224 = 2'd2,
        ALG_SHA256 = 2'd3
    } alg_e;

    // Number of digest words the queue receives for a given algorithm.
    function automatic logic [3:0] depth_of(input alg_e a);
        case (a)
            ALG_MD5:    return 4'd4;
            ALG_SHA1:   return 4'd5;
            ALG_SHA224: return 4'd7;
            default:    return 4'd8;
        endcase
    endfunction
endpackage

// File: rtl/hash_fe_cfg.sv
// Configuration registers: soft reset, 64-bit bit length, control word and
// the "configured since reset" flag. Assumes the top has already decoded
// the write strobes; a write of 1 to the reset register clears the flag.
module hash_fe_cfg
    import hash_fe_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we_rst,
    input  logic          we_hi,
    input  logic          we_lo,
    input  logic          we_ctrl,
    input  logic [DW-1:0] wdata,
    output logic          eng_rst,
    output logic [2*DW-1:0] msg_bits,
    output alg_e          algo,
    output logic [1:0]    byte_order,
    output logic          configured
);
    // Register updates from decoded writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            eng_rst    <= 1'b0;
            msg_bits   <= '0;
            algo       <= ALG_MD5;
            byte_order <= 2'b00;
            configured <= 1'b0;
        end else begin
            if (we_rst) eng_rst <= wdata[0];
            if (we_hi)  msg_bits[2*DW-1:DW] <= wdata;
            if (we_lo)  msg_bits[DW-1:0]    <= wdata;
            if (we_ctrl) begin
                algo       <= alg_e'(wdata[1:0]);
                byte_order <= wdata[9:8];
            end
            if (we_rst && wdata[0]) configured <= 1'b0;
            else if (we_ctrl)       configured <= 1'b1;
        end
    end
endmodule

// File: rtl/hash_fe_irq.sv
// Sticky interrupt status with enable mask and write-one-to-clear.
// Assumes set pulses are single-cycle; a set beats a clear of the same bit.
module hash_fe_irq #(
    parameter int NB = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NB-1:0] set_bits,
    input  logic          clr_we,
    input  logic [NB-1:0] clr_bits,
    input  logic          en_we,
    input  logic [NB-1:0] en_wdata,
    output logic [NB-1:0] status,
    output logic [NB-1:0] enable,
    output logic          irq_any
);
    logic [NB-1:0] clr_mask;

    // Clear mask is active only during a clear write.
    always_comb clr_mask = clr_we ? clr_bits : '0;

    // Status and enable registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status <= '0;
            enable <= '0;
        end else begin
            status <= (status & ~clr_mask) | set_bits;
            if (en_we) enable <= en_wdata;
        end
    end

    // Masked summary.
    always_comb irq_any = |(status & enable);
endmodule

// File: rtl/hash_fe_rq.sv
// Result queue: loads a whole digest, hands out the highest word first, one
// per pop. Assumes flush beats load, and load beats pop in the same cycle.
module hash_fe_rq #(
    parameter int DW    = 32,
    parameter int WORDS = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                flush,
    input  logic                load,
    input  logic [CW-1:0]       depth,
    input  logic [WORDS*DW-1:0] din,
    input  logic                pop,
    output logic [DW-1:0]       dout,
    output logic [CW-1:0]       count
);
    localparam int CW = $clog2(WORDS + 1);
    localparam int IW = (WORDS > 1) ? $clog2(WORDS) : 1;

    logic [DW-1:0] mem [WORDS];
    logic [CW-1:0] top_idx;

    // Digest storage, captured whole on load.
    always_ff @(posedge clk) begin
        if (load) begin
            for (int i = 0; i < WORDS; i++) mem[i] <= din[i*DW +: DW];
        end
    end

    // Fill level.
    always_ff @(posedge clk) begin
        if (!rst_n)                   count <= '0;
        else if (flush)               count <= '0;
        else if (load)                count <= depth;
        else if (pop && count != '0)  count <= count - 1'b1;
    end

    // Head word is the highest remaining index.
    always_comb begin
        top_idx = count - 1'b1;
        dout    = (count == '0) ? '0 : mem[top_idx[IW-1:0]];
    end
endmodule

// File: rtl/hash_fe_top.sv
// Register and interrupt front-end of a hash engine. Decodes the register
// port, routes writes to config, status and queue, and muxes read data.
// Assumes single-cycle accesses with combinational read data.
module hash_fe_top
    import hash_fe_pkg::*;
#(
    parameter int          DW       = 32,
    parameter int          AW       = 8,
    parameter int          WORDS    = 8,
    parameter logic [31:0] REV_ID   = 32'h0001_0203,
    parameter logic [31:0] DESC0_ID = 32'h4853_0001,
    parameter logic [31:0] DESC1_ID = 32'h0000_0F0F
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_req,
    input  logic               reg_wr,
    input  logic [AW-1:0]      reg_addr,
    input  logic [DW-1:0]      reg_wdata,
    output logic [DW-1:0]      reg_rdata,
    input  logic               dig_load,
    input  logic [WORDS*DW-1:0] dig_word,
    input  logic               dat_wr,
    output logic               eng_rst,
    output logic [2*DW-1:0]    msg_bits,
    output logic [1:0]         algo,
    output logic [1:0]         byte_order,
    output logic               irq
);
    localparam int CW = $clog2(WORDS + 1);

    logic wr_en, rd_en;
    logic we_rst, we_hi, we_lo, we_ctrl, en_we, clr_we, rd_pop, flush;
    logic configured, irq_any;
    alg_e algo_q;
    logic [NUM_FLAGS-1:0] st, en, set_bits;
    logic [DW-1:0] rq_word;
    logic [CW-1:0] rq_cnt;
    logic [3:0] dep;

    // Access decode.
    always_comb begin
        wr_en   = reg_req && reg_wr;
        rd_en   = reg_req && !reg_wr;
        we_rst  = wr_en && reg_addr == AW'(OFS_RST);
        we_hi   = wr_en && reg_addr == AW'(OFS_LEN_HI);
        we_lo   = wr_en && reg_addr == AW'(OFS_LEN_LO);
        we_ctrl = wr_en && reg_addr == AW'(OFS_CTRL);
        en_we   = wr_en && reg_addr == AW'(OFS_EN);
        clr_we  = wr_en && reg_addr == AW'(OFS_CLR);
        rd_pop  = rd_en && reg_addr == AW'(OFS_RQ);
        flush   = we_rst && reg_wdata[0];
    end

    // Event sources for the four status flags.
    always_comb begin
        set_bits[0] = dig_load;
        set_bits[1] = dig_load;
        set_bits[2] = rd_pop && rq_cnt == '0;
        set_bits[3] = dat_wr && !configured;
        dep         = depth_of(algo_q);
    end

    hash_fe_cfg #(.DW(DW)) u_cfg (
        .clk(clk), .rst_n(rst_n),
        .we_rst(we_rst), .we_hi(we_hi), .we_lo(we_lo), .we_ctrl(we_ctrl),
        .wdata(reg_wdata),
        .eng_rst(eng_rst), .msg_bits(msg_bits), .algo(algo_q),
        .byte_order(byte_order), .configured(configured)
    );

    hash_fe_irq #(.NB(NUM_FLAGS)) u_irq (
        .clk(clk), .rst_n(rst_n),
        .set_bits(set_bits),
        .clr_we(clr_we), .clr_bits(reg_wdata[NUM_FLAGS-1:0]),
        .en_we(en_we), .en_wdata(reg_wdata[NUM_FLAGS-1:0]),
        .status(st), .enable(en), .irq_any(irq_any)
    );

    hash_fe_rq #(.DW(DW), .WORDS(WORDS)) u_rq (
        .clk(clk), .rst_n(rst_n),
        .flush(flush), .load(dig_load), .depth(CW'(dep)),
        .din(dig_word), .pop(rd_pop),
        .dout(rq_word), .count(rq_cnt)
    );

    // Read data mux.
    always_comb begin
        reg_rdata = '0;
        if (rd_en) begin
            case (reg_addr)
                AW'(OFS_RST):    reg_rdata = DW'(eng_rst);
                AW'(OFS_LEN_HI): reg_rdata = msg_bits[2*DW-1:DW];
                AW'(OFS_LEN_LO): reg_rdata = msg_bits[DW-1:0];
                AW'(OFS_CTRL):   reg_rdata = DW'({byte_order, 6'b0, algo_q});
                AW'(OFS_STAT):   reg_rdata = DW'({irq_any, 4'b0, st});
                AW'(OFS_EN):     reg_rdata = DW'(en);
                AW'(OFS_RQ):     reg_rdata = rq_word;
                AW'(OFS_REV):    reg_rdata = REV_ID;
                AW'(OFS_DESC0):  reg_rdata = DESC0_ID;
                AW'(OFS_DESC1):  reg_rdata = DESC1_ID;
                default:         reg_rdata = '0;
            endcase
        end
    end

    // Output drive.
    always_comb begin
        algo = algo_q;
        irq  = irq_any;
    end
endmodule

// File: rtl/hash_fe_chk.sv
// Temporal checks on the front-end, attached by bind to every instance.
module hash_fe_chk #(
    parameter int CW = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          rd_pop,
    input logic          flush,
    input logic          clr_we,
    input logic          en_we,
    input logic [3:0]    clr_bits,
    input logic [CW-1:0] rq_cnt,
    input logic [3:0]    st,
    input logic          dig_load,
    input logic          dat_wr,
    input logic          eng_rst,
    input logic          irq
);
    // R6
    empty_read_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_pop && rq_cnt == '0) |=> st[2]);

    // R8
    load_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dig_load |=> (st[0] && st[1]));

    // R5
    pop_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_pop && rq_cnt != '0 && !dig_load && !flush) |=> rq_cnt == $past(rq_cnt) - 1'b1);

    // R2
    soft_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (eng_rst && rq_cnt == '0));

    // R9
    clear_bit2_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_we && clr_bits[2]) |=> !st[2]);

    // R10
    irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(dig_load || dat_wr || rd_pop || en_we));
endmodule

bind hash_fe_top hash_fe_chk #(.CW(CW)) u_chk (
    .clk(clk), .rst_n(rst_n), .rd_pop(rd_pop), .flush(flush),
    .clr_we(clr_we), .en_we(en_we), .clr_bits(reg_wdata[3:0]),
    .rq_cnt(rq_cnt), .st(st), .dig_load(dig_load), .dat_wr(dat_wr),
    .eng_rst(eng_rst), .irq(irq)
);

// File: tb/hash_fe_top_tb.sv
// Self-checking bench: sweeps all algorithms, enable masks and status
// patterns, and the same-cycle set/clear overlaps.
module hash_fe_top_tb;
    logic         clk = 0;
    logic         rst_n = 0;
    logic         reg_req = 0, reg_wr = 0;
    logic [7:0]   reg_addr = 0;
    logic [31:0]  reg_wdata = 0;
    logic [31:0]  reg_rdata;
    logic         dig_load = 0;
    logic [255:0] dig_word = 0;
    logic         dat_wr = 0;
    logic         eng_rst, irq;
    logic [63:0]  msg_bits;
    logic [1:0]   algo, byte_order;

    int n_chk = 0, n_bad = 0;
    logic [31:0] rv;

    localparam logic [31:0] REV = 32'h0001_0203;
    localparam logic [31:0] D0  = 32'h4853_0001;
    localparam logic [31:0] D1  = 32'h0000_0F0F;

    hash_fe_top u_dut (
        .clk(clk), .rst_n(rst_n), .reg_req(reg_req), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .dig_load(dig_load), .dig_word(dig_word), .dat_wr(dat_wr),
        .eng_rst(eng_rst), .msg_bits(msg_bits), .algo(algo),
        .byte_order(byte_order), .irq(irq)
    );

    always #4 clk = ~clk;

    task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_req = 1; reg_wr = 1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1;
        reg_req = 0; reg_wr = 0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_req = 1; reg_wr = 0; reg_addr = a;
        #1 d = reg_rdata;
        @(posedge clk); #1;
        reg_req = 0;
    endtask

    task automatic pulse_load();
        @(negedge clk); dig_load = 1;
        @(posedge clk); #1 dig_load = 0;
    endtask

    task automatic pulse_dat();
        @(negedge clk); dat_wr = 1;
        @(posedge clk); #1 dat_wr = 0;
    endtask

    function automatic int depth(input int a);
        return (a == 0) ? 4 : (a == 1) ? 5 : (a == 2) ? 7 : 8;
    endfunction

    function automatic logic [31:0] pat(input int a, input int i);
        return 32'hC0DE_0000 ^ (a << 12) ^ (i * 32'h0101) ^ 32'h55;
    endfunction

    function automatic logic [31:0] stat_exp(input logic [3:0] s, input logic [3:0] m);
        return {23'b0, |(s & m), 4'b0, s};
    endfunction

    // Drive status to exactly pattern s; leaves the block unconfigured.
    task automatic force_status(input logic [3:0] s);
        logic [31:0] tmp;
        wr(8'h00, 1); wr(8'h00, 0);
        pulse_load();
        rd(8'h1C, tmp); // queue empty after flush? load refilled it; drain below
        wr(8'h00, 1); wr(8'h00, 0);
        rd(8'h1C, tmp);
        pulse_dat();
        wr(8'h18, {28'b0, ~s});
    endtask

    initial begin
        #(8 * 150000);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;

        // R1 reset state
        rd(8'h00, rv); chk("R1 rst reg", rv, 0);
        rd(8'h04, rv); chk("R1 len hi", rv, 0);
        rd(8'h08, rv); chk("R1 len lo", rv, 0);
        rd(8'h0C, rv); chk("R1 ctrl", rv, 0);
        rd(8'h10, rv); chk("R1 status", rv, 0);
        rd(8'h14, rv); chk("R1 enable", rv, 0);
        chk("R1 irq", irq, 0);
        chk("R1 eng_rst", eng_rst, 0);

        // R11 identification, writes ignored
        wr(8'h50, 32'hFFFF_FFFF); wr(8'h60, 0); wr(8'h70, 32'h1234_5678);
        rd(8'h50, rv); chk("R11 rev", rv, REV);
        rd(8'h60, rv); chk("R11 desc0", rv, D0);
        rd(8'h70, rv); chk("R11 desc1", rv, D1);

        // R12 unmapped offsets
        for (int a = 0; a < 256; a++) begin
            if (!(a inside {8'h00, 8'h04, 8'h08, 8'h0C, 8'h10, 8'h14, 8'h1C,
                            8'h50, 8'h60, 8'h70})) begin
                rd(8'(a), rv); chk("R12 unmapped", rv, 0);
            end
        end

        // R7 data before configuration sets bit 3; R9 clear
        pulse_dat();
        rd(8'h10, rv); chk("R7 early data", rv, 32'h8);
        wr(8'h18, 32'h8);
        rd(8'h10, rv); chk("R9 clear bit3", rv, 0);

        // R3 length
        wr(8'h04, 32'hDEAD_0001); wr(8'h08, 32'h0000_2A40);
        rd(8'h04, rv); chk("R3 hi", rv, 32'hDEAD_0001);
        rd(8'h08, rv); chk("R3 lo", rv, 32'h0000_2A40);
        chk("R3 msg_bits", msg_bits, 64'hDEAD_0001_0000_2A40);

        // R4, R5, R6, R8 per algorithm
        for (int a = 0; a < 4; a++) begin
            wr(8'h0C, 32'hFFFF_FCFC | a | ((3 - a) << 8));
            rd(8'h0C, rv); chk("R4 ctrl rb", rv, a | ((3 - a) << 8));
            chk("R4 algo", algo, a);
            chk("R4 byte_order", byte_order, 3 - a);
            for (int i = 0; i < 8; i++) dig_word[i*32 +: 32] = pat(a, i);
            pulse_load();
            rd(8'h10, rv); chk("R8 load flags", rv, 32'h3);
            for (int k = 0; k < depth(a); k++) begin
                rd(8'h1C, rv); chk("R5 queue word", rv, pat(a, depth(a) - 1 - k));
            end
            rd(8'h10, rv); chk("R5 no early error", rv, 32'h3);
            rd(8'h1C, rv); chk("R6 empty data", rv, 0);
            rd(8'h10, rv); chk("R6 empty flag", rv, 32'h7);
            wr(8'h18, 32'hF);
        end

        // R7 data after configuration has no effect
        pulse_dat();
        rd(8'h10, rv); chk("R7 configured", rv, 0);

        // R2 soft reset empties queue and unconfigures
        pulse_load();
        wr(8'h18, 32'hF);
        wr(8'h00, 1);
        chk("R2 eng_rst on", eng_rst, 1);
        rd(8'h00, rv); chk("R2 rst rb", rv, 1);
        rd(8'h1C, rv); chk("R2 queue flushed", rv, 0);
        wr(8'h00, 0);
        chk("R2 eng_rst off", eng_rst, 0);
        wr(8'h18, 32'hF);
        pulse_dat();
        rd(8'h10, rv); chk("R2 unconfigured", rv, 32'h8);

        // R10 sweep of status patterns and enable masks
        for (int s = 0; s < 16; s++) begin
            force_status(4'(s));
            for (int m = 0; m < 16; m++) begin
                wr(8'h14, 32'hFFFF_FFF0 | m);
                rd(8'h14, rv); chk("R10 enable rb", rv, m);
                rd(8'h10, rv); chk("R10 status", rv, stat_exp(4'(s), 4'(m)));
                chk("R10 irq", irq, |(4'(s) & 4'(m)));
            end
            wr(8'h14, 0);
        end

        // R9 set beats clear: load with clear of bit 1
        force_status(4'h0);
        @(negedge clk);
        reg_req = 1; reg_wr = 1; reg_addr = 8'h18; reg_wdata = 32'h2; dig_load = 1;
        @(posedge clk); #1 reg_req = 0; reg_wr = 0; dig_load = 0;
        rd(8'h10, rv); chk("R9 load vs clear", rv, 32'h3);

        // R9 set beats clear: early data with clear of bit 3
        wr(8'h18, 32'hF);
        @(negedge clk);
        reg_req = 1; reg_wr = 1; reg_addr = 8'h18; reg_wdata = 32'h8; dat_wr = 1;
        @(posedge clk); #1 reg_req = 0; reg_wr = 0; dat_wr = 0;
        rd(8'h10, rv); chk("R9 data vs clear", rv, 32'h8);

        // R9 selective clear
        pulse_load();
        wr(8'h18, 32'h1);
        rd(8'h10, rv); chk("R9 selective", rv, 32'hA);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule